// File: doc/BRIEF.md
# Multiframe Pager Address Matcher

This block checks a stream of received paging codewords against a table of programmed call addresses. The codewords have already been through error correction, and each one arrives with a valid strobe and a flag that marks it as uncorrectable. A separate sync detector pulses `sync_found` when it finds the batch sync word. A batch is that sync word followed by eight frames of two codewords each. After the pulse, the block counts codeword positions so that it always knows which frame the current codeword belongs to.

The table has eight slots. Each slot holds an 18-bit address, a 3-bit frame assignment and an enable bit. Any slot can sit in any frame, so one decoder can listen in several frames at once. An address codeword carries a 2-bit function code, which selects one of four sub-addresses. This gives 8 × 4 = 32 separate call identities. When an enabled slot matches in its own frame, the block raises a one-clock pulse. The pulse carries the slot index, the sub-address and the call type (tone-only, numeric or character) that the sub-address implies.

The position tracker is a two-state machine. In `TRK_HUNT` no sync has been seen, or the last batch has finished, and codewords are not counted. In `TRK_FRAMES` positions 0 to 15 are counted. The transitions are: *sync-enter*, where `sync_found` goes to `TRK_FRAMES` at position 0 from either state; *advance*, where a valid codeword in `TRK_FRAMES` adds one to the position; and *batch-end*, where the valid codeword at position 15 returns to `TRK_HUNT`.

Top module: `paging_addr_match`

## Requirements
- R1: After reset `hit_pulse` is 0, `hit_kind` is 0, and the tracker is in `TRK_HUNT`.
- R2: No codeword produces a hit before the first `sync_found` pulse.
- R3: A codeword that qualifies raises `hit_pulse` in the clock cycle after the one in which `cw_valid` was sampled. A codeword qualifies when it is valid, is an address codeword (bit 31 = 0), and bits 30..13 equal the address of an enabled slot whose frame number equals position/2. With the pulse, `hit_slot` gives the slot index and `hit_sub` gives bits 12..11.
- R4: An address that matches a slot but arrives in a frame other than the slot's assigned frame produces no hit.
- R5: A slot whose enable bit is 0 never produces a hit. Setting its enable bit to 1 makes it match.
- R6: A message codeword (bit 31 = 1) never produces a hit.
- R7: The idle codeword 0x7A89C197 never produces a hit, even when a slot holds its address bits in the current frame.
- R8: A codeword with `cw_bad` = 1 produces no hit, but it still advances the position count.
- R9: `sync_found` resets the position to 0 at any time. The sync-cycle codeword is ignored. After 16 valid codewords, further codewords are ignored until the next `sync_found`.
- R10: When several enabled slots match the same codeword, the lowest slot index is reported.
- R11: `hit_kind` encodes the call type: 1 = tone for sub 01 and 10, 2 = numeric for sub 00, 3 = character for sub 11. `hit_kind` is 0 in every cycle without a hit.
- R12: `hit_pulse` is high for exactly one clock cycle per qualifying codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_found | input | 1 | Batch sync word detected (one-cycle pulse) |
| cw_valid | input | 1 | Codeword strobe |
| cw_bad | input | 1 | Codeword could not be corrected |
| cw_data | input | 32 | Received codeword |
| slot_addr | input | 144 | Eight 18-bit slot addresses; slot i is at bits [18i+17:18i] |
| slot_frame | input | 24 | Eight 3-bit frame assignments; slot i is at bits [3i+2:3i] |
| slot_en | input | 8 | Per-slot enable |
| hit_pulse | output | 1 | One-cycle match pulse |
| hit_slot | output | 3 | Index of the matching slot |
| hit_sub | output | 2 | Received sub-address |
| hit_kind | output | 2 | Call type |

## Verification
The bench sends the idle word into a frame where one slot holds the idle word's address bits. A matcher that only checks bit 31 would report a call there.

Two uncorrectable codewords are sent first in a batch, followed by a matching address at position 2. A design that does not count bad words would see frame 0 and report a false hit.

A matching address is also sent right after a batch ends. A tracker that wraps around to frame 0 would match it.

Two identical slots test the priority order. A run of back-to-back codewords shows whether a pulse lasts longer than one cycle.

// File: rtl/pam_pkg.sv
package pam_pkg;
    localparam int CW_W = 32;
    localparam logic [CW_W-1:0] IDLE_CW = 32'h7A89C197;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_TONE = 2'd1,
        KIND_NUM  = 2'd2,
        KIND_CHAR = 2'd3
    } call_kind_e;

    typedef enum logic {
        TRK_HUNT   = 1'b0,
        TRK_FRAMES = 1'b1
    } trk_state_e;

    function automatic call_kind_e kind_of(input logic [1:0] sub);
        call_kind_e k;
        unique case (sub)
            2'b00:   k = KIND_NUM;
            2'b11:   k = KIND_CHAR;
            default: k = KIND_TONE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/pam_pos_track.sv
module pam_pos_track
    import pam_pkg::*;
#(
    parameter int FRAMES       = 8,
    parameter int CW_PER_FRAME = 2,
    parameter int FRAME_W      = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_found,
    input  logic               cw_valid,
    output logic               in_batch,
    output logic [FRAME_W-1:0] frame_idx
);
    localparam int POS_N = FRAMES * CW_PER_FRAME;
    localparam int POS_W = $clog2(POS_N);

    trk_state_e       st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TRK_HUNT;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // Next state: sync-enter, advance, batch-end
    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        if (sync_found) begin
            st_d  = TRK_FRAMES;
            pos_d = '0;
        end else begin
            unique case (st_q)
                TRK_HUNT: begin
                    pos_d = '0;
                end
                TRK_FRAMES: begin
                    if (cw_valid) begin
                        if (pos_q == POS_W'(POS_N - 1)) begin
                            st_d  = TRK_HUNT;
                            pos_d = '0;
                        end else begin
                            pos_d = pos_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_batch  = (st_q == TRK_FRAMES);
        frame_idx = FRAME_W'(pos_q / POS_W'(CW_PER_FRAME));
    end
endmodule

// File: rtl/pam_slot_cmp.sv
module pam_slot_cmp #(
    parameter int N_SLOTS = 8,
    parameter int ADDR_W  = 18,
    parameter int FRAME_W = 3
) (
    input  logic [ADDR_W-1:0]          cw_addr,
    input  logic [FRAME_W-1:0]         frame_idx,
    input  logic [N_SLOTS*ADDR_W-1:0]  slot_addr,
    input  logic [N_SLOTS*FRAME_W-1:0] slot_frame,
    input  logic [N_SLOTS-1:0]         slot_en,
    output logic [N_SLOTS-1:0]         hit
);
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        assign hit[i] = slot_en[i]
                     && (slot_frame[i*FRAME_W +: FRAME_W] == frame_idx)
                     && (slot_addr[i*ADDR_W +: ADDR_W] == cw_addr);
    end
endmodule

// File: rtl/pam_prio_enc.sv
module pam_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/paging_addr_match.sv
module paging_addr_match
    import pam_pkg::*;
#(
    parameter int N_SLOTS      = 8,
    parameter int ADDR_W       = 18,
    parameter int FRAMES       = 8,
    parameter int CW_PER_FRAME = 2,
    parameter int SUB_W        = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    sync_found,
    input  logic                                    cw_valid,
    input  logic                                    cw_bad,
    input  logic [CW_W-1:0]                         cw_data,
    input  logic [N_SLOTS*ADDR_W-1:0]               slot_addr,
    input  logic [N_SLOTS*$clog2(FRAMES)-1:0]       slot_frame,
    input  logic [N_SLOTS-1:0]                      slot_en,
    output logic                                    hit_pulse,
    output logic [$clog2(N_SLOTS)-1:0]              hit_slot,
    output logic [SUB_W-1:0]                        hit_sub,
    output logic [1:0]                              hit_kind
);
    localparam int FRAME_W  = $clog2(FRAMES);
    localparam int SLOT_W   = $clog2(N_SLOTS);
    localparam int ADDR_MSB = CW_W - 2;
    localparam int SUB_MSB  = ADDR_MSB - ADDR_W;

    logic               in_batch;
    logic [FRAME_W-1:0] frame_idx;
    logic [N_SLOTS-1:0] slot_hit;
    logic               any_hit;
    logic [SLOT_W-1:0]  win_idx;
    logic               qualify;
    logic [SUB_W-1:0]   rx_sub;

    pam_pos_track #(
        .FRAMES       (FRAMES),
        .CW_PER_FRAME (CW_PER_FRAME),
        .FRAME_W      (FRAME_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_found (sync_found),
        .cw_valid   (cw_valid),
        .in_batch   (in_batch),
        .frame_idx  (frame_idx)
    );

    pam_slot_cmp #(
        .N_SLOTS (N_SLOTS),
        .ADDR_W  (ADDR_W),
        .FRAME_W (FRAME_W)
    ) u_cmp (
        .cw_addr    (cw_data[ADDR_MSB -: ADDR_W]),
        .frame_idx  (frame_idx),
        .slot_addr  (slot_addr),
        .slot_frame (slot_frame),
        .slot_en    (slot_en),
        .hit        (slot_hit)
    );

    pam_prio_enc #(
        .N     (N_SLOTS),
        .IDX_W (SLOT_W)
    ) u_prio (
        .req   (slot_hit),
        .found (any_hit),
        .idx   (win_idx)
    );

    assign rx_sub  = cw_data[SUB_MSB -: SUB_W];
    assign qualify = cw_valid && !sync_found && in_batch && !cw_bad
                  && !cw_data[CW_W-1] && (cw_data != IDLE_CW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_pulse <= 1'b0;
            hit_slot  <= '0;
            hit_sub   <= '0;
            hit_kind  <= KIND_NONE;
        end else if (qualify && any_hit) begin
            hit_pulse <= 1'b1;
            hit_slot  <= win_idx;
            hit_sub   <= rx_sub;
            hit_kind  <= kind_of(rx_sub[1:0]);
        end else begin
            hit_pulse <= 1'b0;
            hit_slot  <= '0;
            hit_sub   <= '0;
            hit_kind  <= KIND_NONE;
        end
    end
endmodule

// File: rtl/pam_chk.sv
module pam_chk
    import pam_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int SLOT_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_found,
    input logic               cw_valid,
    input logic               cw_bad,
    input logic [CW_W-1:0]    cw_data,
    input logic [N_SLOTS-1:0] slot_en,
    input logic               hit_pulse,
    input logic [SLOT_W-1:0]  hit_slot,
    input logic [1:0]         hit_kind
);
    logic [N_SLOTS-1:0] en_q;
    always_ff @(posedge clk) en_q <= slot_en;

    // R3
    src_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> ($past(cw_valid) && !$past(sync_found)));

    // R5
    slot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> en_q[hit_slot]);

    // R6
    msg_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> !$past(cw_data[CW_W-1]));

    // R7
    idle_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> ($past(cw_data) != IDLE_CW));

    // R8
    bad_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> !$past(cw_bad));

    // R11
    quiet_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_kind != KIND_NONE) == hit_pulse);
endmodule

bind paging_addr_match pam_chk #(
    .N_SLOTS (N_SLOTS),
    .SLOT_W  ($clog2(N_SLOTS))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_found (sync_found),
    .cw_valid   (cw_valid),
    .cw_bad     (cw_bad),
    .cw_data    (cw_data),
    .slot_en    (slot_en),
    .hit_pulse  (hit_pulse),
    .hit_slot   (hit_slot),
    .hit_kind   (hit_kind)
);

// File: tb/sim_paging_addr_match.sv
module sim_paging_addr_match;
    localparam int NS = 8;
    localparam int AW = 18;
    localparam logic [31:0] IDLE = 32'h7A89C197;

    typedef struct {
        bit       hit;
        bit [2:0] slot;
        bit [1:0] sub;
        bit [1:0] kind;
        string    req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_found = 1'b0;
    logic          cw_valid = 1'b0;
    logic          cw_bad = 1'b0;
    logic [31:0]   cw_data = '0;
    logic [NS*AW-1:0] slot_addr;
    logic [NS*3-1:0]  slot_frame;
    logic [NS-1:0]    slot_en;
    logic          hit_pulse;
    logic [2:0]    hit_slot;
    logic [1:0]    hit_sub;
    logic [1:0]    hit_kind;

    logic [AW-1:0] m_addr [NS];
    logic [2:0]    m_frame [NS];
    logic          m_en [NS];

    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    bit   seen = 0;
    exp_t q[$];
    int   m_pos = 0;
    bit   m_in = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            slot_addr[i*AW +: AW] = m_addr[i];
            slot_frame[i*3 +: 3]  = m_frame[i];
            slot_en[i]            = m_en[i];
        end
    end

    paging_addr_match u0 (
        .clk(clk), .rst_n(rst_n), .sync_found(sync_found), .cw_valid(cw_valid),
        .cw_bad(cw_bad), .cw_data(cw_data), .slot_addr(slot_addr),
        .slot_frame(slot_frame), .slot_en(slot_en), .hit_pulse(hit_pulse),
        .hit_slot(hit_slot), .hit_sub(hit_sub), .hit_kind(hit_kind)
    );

    function automatic logic [31:0] mk(input logic [AW-1:0] a, input logic [1:0] s);
        return {1'b0, a, s, 11'h2B3};
    endfunction

    function automatic bit [1:0] kind_m(input bit [1:0] s);
        if (s == 2'b00) return 2'd2;
        if (s == 2'b11) return 2'd3;
        return 2'd1;
    endfunction

    task automatic sync_pulse();
        sync_found = 1'b1;
        @(negedge clk);
        sync_found = 1'b0;
        m_pos = 0;
        m_in  = 1;
    endtask

    // Driver: computes the expected result and queues it
    task automatic send(input logic [31:0] d, input bit bad, input string req);
        exp_t e;
        e.hit = 0; e.slot = 0; e.sub = 0; e.kind = 0; e.req = req;
        if (m_in && !bad && !d[31] && d != IDLE) begin
            for (int i = NS - 1; i >= 0; i--) begin
                if (m_en[i] && m_frame[i] == 3'(m_pos / 2) && m_addr[i] == d[30:13]) begin
                    e.hit = 1; e.slot = 3'(i);
                end
            end
            if (e.hit) begin
                e.sub  = d[12:11];
                e.kind = kind_m(d[12:11]);
            end
        end
        if (m_in) begin
            m_pos++;
            if (m_pos == 16) begin m_in = 0; m_pos = 0; end
        end
        q.push_back(e);
        cw_data  = d;
        cw_bad   = bad;
        cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        cw_bad   = 1'b0;
    endtask

    always @(posedge clk) seen <= cw_valid;

    // Monitor: compares each codeword's result against the queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (seen) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard: result with no queued item, act pulse=%0b exp none", hit_pulse);
                end else begin
                    e = q.pop_front();
                    if (hit_pulse !== e.hit || (e.hit && (hit_slot !== e.slot ||
                        hit_sub !== e.sub || hit_kind !== e.kind)) ||
                        (!e.hit && hit_kind !== 2'd0)) begin
                        fails++;
                        $display("FAIL %s: act pulse=%0b slot=%0d sub=%0d kind=%0d exp pulse=%0b slot=%0d sub=%0d kind=%0d",
                                 e.req, hit_pulse, hit_slot, hit_sub, hit_kind,
                                 e.hit, e.slot, e.sub, e.kind);
                    end
                end
            end else if (hit_pulse) begin
                checks++;
                fails++;
                $display("FAIL R12: act pulse=1 exp 0 with no codeword before it");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: act running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_addr[i] = AW'(18'h01000 + i * 18'h333);
            m_frame[i] = 3'(i);
            m_en[i] = 1'b0;
        end
        m_addr[0] = 18'h12345; m_frame[0] = 3'd0; m_en[0] = 1'b1;
        m_addr[1] = 18'h2AAAA; m_frame[1] = 3'd3; m_en[1] = 1'b1;
        m_addr[2] = 18'h2AAAA; m_frame[2] = 3'd3; m_en[2] = 1'b1;
        m_addr[3] = 18'h3D44E; m_frame[3] = 3'd0; m_en[3] = 1'b1;
        m_addr[4] = 18'h11111; m_frame[4] = 3'd7; m_en[4] = 1'b0;

        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (hit_pulse !== 1'b0 || hit_kind !== 2'd0) begin
            fails++;
            $display("FAIL R1: act pulse=%0b kind=%0d exp 0 0", hit_pulse, hit_kind);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no sync yet
        send(mk(18'h12345, 2'd0), 0, "R2");

        // Batch 1
        sync_pulse();
        send(mk(18'h12345, 2'd2), 0, "R3 R11 tone");
        send(IDLE, 0, "R7");
        send(mk(18'h12345, 2'd0), 0, "R4");
        send(IDLE, 0, "R9 pos3");
        send(IDLE, 0, "R9 pos4");
        send(IDLE, 0, "R9 pos5");
        send(mk(18'h2AAAA, 2'd3), 0, "R10 R11 char");
        send({1'b1, 18'h2AAAA, 13'h0}, 0, "R6 R12");
        for (int k = 0; k < 6; k++) send(IDLE, 0, "R9 fill");
        send(mk(18'h11111, 2'd1), 0, "R5 disabled");
        send(IDLE, 0, "R9 pos15");
        send(mk(18'h12345, 2'd0), 0, "R9 after batch");

        // Batch 2: bad words advance position, mid-batch sync
        sync_pulse();
        send(mk(18'h12345, 2'd1), 1, "R8 bad");
        send(mk(18'h12345, 2'd1), 1, "R8 bad");
        send(mk(18'h12345, 2'd0), 0, "R8 position");
        send(IDLE, 0, "R9 pos3");
        sync_pulse();
        send(mk(18'h12345, 2'd0), 0, "R9 resync R11 numeric");
        send(mk(18'h12345, 2'd3), 0, "R12 back to back");

        // Batch 3: enable slot 4
        m_en[4] = 1'b1;
        sync_pulse();
        for (int k = 0; k < 14; k++) send(IDLE, 0, "R9 fill");
        send(mk(18'h11111, 2'd1), 0, "R5 enabled");
        send(IDLE, 0, "R12");

        repeat (4) @(negedge clk);
        done = 1;
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R3: act %0d results pending exp 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule